// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel Sequencer

This block is a single DMA channel that takes its work from a ring of descriptors kept in memory rather than from registers. A start pulse hands it the address of the first descriptor. The channel reads that descriptor through a plain word-read/word-write memory port and checks that the descriptor is valid. It then copies the described bytes from source to destination through the same port and marks the descriptor as consumed by writing its header back with the valid flag cleared. If the descriptor asks for chaining, the channel continues at the address held in the descriptor's link word.

A chain ends in one of three ways. The channel may reach a descriptor whose valid flag is clear, which includes a ring that wraps back onto descriptors it has already retired. A descriptor may leave chaining switched off. Or a descriptor may carry an inconsistent byte count or size code, which stops the channel with an error. Each descriptor chooses whether its completion raises the end interrupt, so a driver can mask every link except the last. The memory port has a fixed read latency of one cycle: read data for a request accepted at one clock edge is valid for the whole following cycle.

Top module: `lnk_chan_seq`

## Requirements
- R1: After reset, busy, endIrq, errFlag and memReq are all 0.
- R2: A start pulse while idle raises busy and, in the next cycle, issues a read of startAddr (the header word). A start pulse while busy is ignored.
- R3: When a fetched header has bit 0 (valid) equal to 0, the channel performs no transfer and no write, raises no interrupt, leaves errFlag at 0, and drops busy three cycles after the header read request.
- R4: A descriptor is eight 32-bit words at byte offsets 0,4,...,28: header, source address, destination address, byte count, configuration, two unused words (interval and extension, ignored), next-link address.
- R5: In the configuration word, bits 15:12 hold the source size code and bits 19:16 the destination size code, where code c means 2^c bytes per access (c = 0..7). The channel performs count >> srcCode read/write pairs. Each pair reads the source word and writes it to the destination word. Source and destination addresses advance by their own access size.
- R6: Configuration bit 20 holds the source address and bit 21 holds the destination address constant for every access of that descriptor.
- R7: After its last write, the descriptor's header is written back with bit 0 cleared and all other bits unchanged. This happens before any further descriptor fetch.
- R8: After the retire write, endIrq pulses for exactly one cycle if configuration bit 24 is 0. If bit 24 is 1, no pulse occurs.
- R9: When configuration bit 31 is 1, the channel fetches the next descriptor from the next-link word. A ring that wraps onto a retired descriptor stops there.
- R10: When configuration bit 31 is 0, the channel goes idle after retiring the descriptor and does not follow the next-link word.
- R11: A byte count of zero, a size code above 7, or a count that is not a multiple of either access size sets errFlag and drops busy without any transfer or retire write. errFlag stays set until the next accepted start clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, accepted only while idle |
| startAddr | input | ADDR_W | Byte address of the first descriptor |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Access is a write when 1 |
| memAddr | output | ADDR_W | Byte address of the access |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid the cycle after a read request |
| busy | output | 1 | Channel enabled and running |
| endIrq | output | 1 | One-cycle end-of-descriptor interrupt |
| errFlag | output | 1 | Sticky descriptor error flag |

## Verification
The first header read appears one cycle after the start pulse is sampled, and the bench checks memReq and memAddr in exactly that cycle. An invalid header clears busy on the third cycle after that read, and the bench checks the cycle before that edge and the cycle after it. Copy results, retire write-backs, interrupt counts and the error flag only settle once busy has fallen, so those checks wait for busy to drop under a cycle cap and then sample the bench memory and the counters. Every sample is taken on the falling clock edge.

// File: rtl/lnk_pkg.sv
package lnk_pkg;

  localparam int WORD_W = 32;

  // descriptor word indices (order is decoded by the fetch sequence)
  localparam logic [2:0] W_HDR  = 3'd0;
  localparam logic [2:0] W_SRC  = 3'd1;
  localparam logic [2:0] W_DST  = 3'd2;
  localparam logic [2:0] W_CNT  = 3'd3;
  localparam logic [2:0] W_CFG  = 3'd4;
  localparam logic [2:0] W_NEXT = 3'd7;

  // configuration word field positions
  localparam int CFG_LINK    = 31;
  localparam int CFG_IRQMSK  = 24;
  localparam int CFG_DSTFIX  = 21;
  localparam int CFG_SRCFIX  = 20;
  localparam int CFG_DSZ_LO  = 16;
  localparam int CFG_SSZ_LO  = 12;
  localparam int HDR_VALID   = 0;

  typedef enum logic [1:0] {
    SEL_DESC = 2'd0,
    SEL_SRC  = 2'd1,
    SEL_DST  = 2'd2
  } addrSel_e;

  typedef struct packed {
    logic       loadStart;
    logic       followLink;
    logic       capWord;
    logic [2:0] wordIdx;
    logic       initXfer;
    logic       capData;
    logic       stepXfer;
    addrSel_e   addrSel;
  } ctlStrobe_t;

  typedef struct packed {
    logic hdrValid;
    logic cfgBad;
    logic lastAccess;
    logic linkMode;
    logic irqMask;
  } dpStatus_t;

endpackage

// File: rtl/lnk_dpath.sv
module lnk_dpath
  import lnk_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [WORD_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output dpStatus_t         status
);

  localparam int SZ_W = 4;

  logic [ADDR_W-1:0] linkAddr, nextLink, srcAddr, dstAddr;
  logic [WORD_W-1:0] hdrWord, cntWord, dataHold, remain;
  logic [SZ_W-1:0]   srcCode, dstCode;
  logic              linkEn, irqMsk, srcFix, dstFix;

  logic [ADDR_W-1:0] descAddr, srcStep, dstStep;
  logic [WORD_W-1:0] srcMask, dstMask;
  logic              sizeOk;

  assign descAddr = linkAddr + ADDR_W'({ctl.wordIdx, 2'b00});
  assign srcStep  = ADDR_W'(1) << srcCode[2:0];
  assign dstStep  = ADDR_W'(1) << dstCode[2:0];
  assign srcMask  = (WORD_W'(1) << srcCode[2:0]) - WORD_W'(1);
  assign dstMask  = (WORD_W'(1) << dstCode[2:0]) - WORD_W'(1);
  assign sizeOk   = !srcCode[3] && !dstCode[3];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      linkAddr <= '0;
      nextLink <= '0;
      srcAddr  <= '0;
      dstAddr  <= '0;
      hdrWord  <= '0;
      cntWord  <= '0;
      dataHold <= '0;
      remain   <= '0;
      srcCode  <= '0;
      dstCode  <= '0;
      linkEn   <= 1'b0;
      irqMsk   <= 1'b0;
      srcFix   <= 1'b0;
      dstFix   <= 1'b0;
    end else begin
      if (ctl.loadStart)       linkAddr <= startAddr;
      else if (ctl.followLink) linkAddr <= nextLink;

      if (ctl.capWord) begin
        case (ctl.wordIdx)
          W_HDR:  hdrWord <= memRdata;
          W_SRC:  srcAddr <= memRdata[ADDR_W-1:0];
          W_DST:  dstAddr <= memRdata[ADDR_W-1:0];
          W_CNT:  cntWord <= memRdata;
          W_CFG: begin
            linkEn  <= memRdata[CFG_LINK];
            irqMsk  <= memRdata[CFG_IRQMSK];
            dstFix  <= memRdata[CFG_DSTFIX];
            srcFix  <= memRdata[CFG_SRCFIX];
            dstCode <= memRdata[CFG_DSZ_LO +: SZ_W];
            srcCode <= memRdata[CFG_SSZ_LO +: SZ_W];
          end
          W_NEXT: nextLink <= memRdata[ADDR_W-1:0];
          default: ;
        endcase
      end

      if (ctl.initXfer) remain <= cntWord >> srcCode[2:0];

      if (ctl.capData) dataHold <= memRdata;

      if (ctl.stepXfer) begin
        remain <= remain - WORD_W'(1);
        if (!srcFix) srcAddr <= srcAddr + srcStep;
        if (!dstFix) dstAddr <= dstAddr + dstStep;
      end
    end
  end

  always_comb begin
    case (ctl.addrSel)
      SEL_SRC: memAddr = srcAddr;
      SEL_DST: memAddr = dstAddr;
      default: memAddr = descAddr;
    endcase
  end

  // retire write carries the header with its valid flag dropped
  assign memWdata = (ctl.addrSel == SEL_DESC) ?
                    (hdrWord & ~(WORD_W'(1) << HDR_VALID)) : dataHold;

  assign status.hdrValid   = hdrWord[HDR_VALID];
  assign status.cfgBad     = (cntWord == '0) || !sizeOk ||
                             ((cntWord & srcMask) != '0) ||
                             ((cntWord & dstMask) != '0);
  assign status.lastAccess = (remain == WORD_W'(1));
  assign status.linkMode   = linkEn;
  assign status.irqMask    = irqMsk;

  // R6: a fixed source address does not move across an access
  p_src_fixed_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.stepXfer && srcFix) |=> $stable(srcAddr));

  // R6: a fixed destination address does not move across an access
  p_dst_fixed_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.stepXfer && dstFix) |=> $stable(dstAddr));

  // R11: a transfer is never started on an inconsistent descriptor
  p_no_bad_xfer_r11: assert property (@(posedge clk) disable iff (!rstN)
    ctl.initXfer |-> !status.cfgBad);

endmodule

// File: rtl/lnk_ctrl.sv
module lnk_ctrl
  import lnk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  dpStatus_t  status,
  output ctlStrobe_t ctl,
  output logic       memReq,
  output logic       memWe,
  output logic       busy,
  output logic       endIrq,
  output logic       errFlag
);

  typedef enum logic [3:0] {
    S_IDLE, S_HREQ, S_HCAP, S_HCHK, S_BREQ, S_BCAP, S_CHK,
    S_RREQ, S_RCAP, S_WREQ, S_RETIRE, S_DONE
  } state_e;

  state_e     state, stateNxt;
  logic [2:0] wordCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      wordCnt <= '0;
      endIrq  <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      state  <= stateNxt;
      endIrq <= (state == S_DONE) && !status.irqMask;
      if (state == S_IDLE && start)                errFlag <= 1'b0;
      else if (state == S_CHK && status.cfgBad)    errFlag <= 1'b1;
      if (state == S_HCHK)                         wordCnt <= W_SRC;
      else if (state == S_BCAP)                    wordCnt <= wordCnt + 3'd1;
    end
  end

  always_comb begin
    stateNxt    = state;
    ctl         = '0;
    ctl.addrSel = SEL_DESC;
    memReq      = 1'b0;
    memWe       = 1'b0;
    case (state)
      S_IDLE: if (start) begin
        ctl.loadStart = 1'b1;
        stateNxt      = S_HREQ;
      end
      S_HREQ: begin
        memReq   = 1'b1;
        stateNxt = S_HCAP;
      end
      S_HCAP: begin
        ctl.capWord = 1'b1;
        ctl.wordIdx = W_HDR;
        stateNxt    = S_HCHK;
      end
      S_HCHK: stateNxt = status.hdrValid ? S_BREQ : S_IDLE;
      S_BREQ: begin
        memReq      = 1'b1;
        ctl.wordIdx = wordCnt;
        stateNxt    = S_BCAP;
      end
      S_BCAP: begin
        ctl.capWord = 1'b1;
        ctl.wordIdx = wordCnt;
        stateNxt    = (wordCnt == W_NEXT) ? S_CHK : S_BREQ;
      end
      S_CHK: begin
        if (status.cfgBad) stateNxt = S_IDLE;
        else begin
          ctl.initXfer = 1'b1;
          stateNxt     = S_RREQ;
        end
      end
      S_RREQ: begin
        memReq      = 1'b1;
        ctl.addrSel = SEL_SRC;
        stateNxt    = S_RCAP;
      end
      S_RCAP: begin
        ctl.capData = 1'b1;
        stateNxt    = S_WREQ;
      end
      S_WREQ: begin
        memReq       = 1'b1;
        memWe        = 1'b1;
        ctl.addrSel  = SEL_DST;
        ctl.stepXfer = 1'b1;
        stateNxt     = status.lastAccess ? S_RETIRE : S_RREQ;
      end
      S_RETIRE: begin
        memReq      = 1'b1;
        memWe       = 1'b1;
        ctl.wordIdx = W_HDR;
        stateNxt    = S_DONE;
      end
      S_DONE: begin
        if (status.linkMode) begin
          ctl.followLink = 1'b1;
          stateNxt       = S_HREQ;
        end else begin
          stateNxt = S_IDLE;
        end
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);

  // R8: the end interrupt is a single-cycle pulse
  p_irq_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    endIrq |=> !endIrq);

  // R2: the channel only becomes busy after a start pulse
  p_busy_on_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

  // R11: the error flag rises only together with the channel stopping
  p_err_stops_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> !busy);

  // R3: an invalid header stops the channel on the next cycle
  p_invalid_stop_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_HCHK && !status.hdrValid) |=> !busy);

endmodule

// File: rtl/lnk_chan_seq.sv
module lnk_chan_seq
  import lnk_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] startAddr,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata,
  output logic              busy,
  output logic              endIrq,
  output logic              errFlag
);

  ctlStrobe_t ctl;
  dpStatus_t  status;

  lnk_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .status  (status),
    .ctl     (ctl),
    .memReq  (memReq),
    .memWe   (memWe),
    .busy    (busy),
    .endIrq  (endIrq),
    .errFlag (errFlag)
  );

  lnk_dpath #(.ADDR_W(ADDR_W)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .startAddr (startAddr),
    .memRdata  (memRdata),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .status    (status)
  );

  // R7: a write is always a request
  p_we_needs_req_r7: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> memReq);

  // R7: the retire write never leaves the valid flag set
  p_retire_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && ctl.addrSel == SEL_DESC) |-> !memWdata[0]);

  // R1: no memory traffic while idle
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReq);

endmodule

// File: tb/sim_lnk_chan_seq.sv
module sim_lnk_chan_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] startAddr = '0;
  logic        memReq, memWe, busy, endIrq, errFlag;
  logic [31:0] memAddr, memWdata;
  logic [31:0] memRdata;

  logic        tbWe = 1'b0;
  logic [31:0] tbAddr = '0, tbData = '0;
  logic [31:0] mem [0:1023];
  int          wrCnt = 0, irqCnt = 0;
  int          checks = 0, errors = 0;

  always #10 clk = ~clk;

  lnk_chan_seq #(.ADDR_W(32)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .startAddr(startAddr),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata),
    .busy(busy), .endIrq(endIrq), .errFlag(errFlag)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 1024; i++) mem[i] <= '0;
      memRdata <= '0;
    end else begin
      if (tbWe) mem[tbAddr[11:2]] <= tbData;
      if (memReq) begin
        if (memWe) begin
          mem[memAddr[11:2]] <= memWdata;
          wrCnt <= wrCnt + 1;
        end else begin
          memRdata <= mem[memAddr[11:2]];
        end
      end
      if (endIrq) irqCnt <= irqCnt + 1;
    end
  end

  typedef struct packed {
    logic [31:0] cfg;
    logic [31:0] cnt;
    logic        err;
    logic        irq;
  } vec_t;

  localparam vec_t VECS [0:9] = '{
    '{32'h80400008, 32'd8,  1'b0, 1'b1},  // byte copy, memcpy config
    '{32'h80022000, 32'd16, 1'b0, 1'b1},  // word copy
    '{32'h81022000, 32'd12, 1'b0, 1'b0},  // interrupt masked
    '{32'h80122000, 32'd16, 1'b0, 1'b1},  // source fixed
    '{32'h80222000, 32'd16, 1'b0, 1'b1},  // destination fixed
    '{32'h80032000, 32'd16, 1'b0, 1'b1},  // destination 8-byte steps
    '{32'h80022000, 32'd0,  1'b1, 1'b0},  // zero count
    '{32'h80022000, 32'd10, 1'b1, 1'b0},  // count not word multiple
    '{32'h80082000, 32'd16, 1'b1, 1'b0},  // size code out of range
    '{32'h80011000, 32'd6,  1'b0, 1'b1}   // halfword copy
  };

  task automatic check(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    tbWe = 1'b1; tbAddr = a; tbData = d;
    @(negedge clk);
    tbWe = 1'b0;
  endtask

  task automatic putDesc(input logic [31:0] base, input logic [31:0] hdr,
                         input logic [31:0] sa, input logic [31:0] da,
                         input logic [31:0] cnt, input logic [31:0] cfg,
                         input logic [31:0] nxt);
    poke(base,      hdr);
    poke(base + 4,  sa);
    poke(base + 8,  da);
    poke(base + 12, cnt);
    poke(base + 16, cfg);
    poke(base + 20, 32'hDEADBEEF);
    poke(base + 24, 32'h12345678);
    poke(base + 28, nxt);
  endtask

  task automatic pulseStart(input logic [31:0] a);
    @(negedge clk);
    start = 1'b1; startAddr = a;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitIdle();
    for (int n = 0; n < 5000 && busy; n++) @(negedge clk);
  endtask

  task automatic clearDst();
    for (int k = 0; k < 16; k++) poke(32'h400 + 32'(k * 4), 32'h0);
  endtask

  logic [31:0] expD [0:15];

  initial begin : main
    int irq0, wr0, bad;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !endIrq && !errFlag && !memReq, "R1 reset state",
          {28'h0, busy, endIrq, errFlag, memReq}, 32'h0);

    for (int k = 0; k < 8; k++) poke(32'h200 + 32'(k * 4), 32'hA5000000 + 32'(k * 32'h01010101));

    // table of descriptor configurations
    for (int v = 0; v < 10; v++) begin
      int sc, dc, n;
      clearDst();
      putDesc(32'h100, 32'h00000A01, 32'h200, 32'h400,
              VECS[v].cnt, VECS[v].cfg, 32'h100);
      for (int k = 0; k < 16; k++) expD[k] = 32'h0;
      if (!VECS[v].err) begin
        sc = int'(VECS[v].cfg[15:12]);
        dc = int'(VECS[v].cfg[19:16]);
        n  = int'(VECS[v].cnt) >> sc;
        for (int i = 0; i < n; i++) begin
          int sa, da;
          sa = 32'h200 + (VECS[v].cfg[20] ? 0 : (i << sc));
          da = (VECS[v].cfg[21] ? 0 : (i << dc));
          expD[da >> 2] = mem[sa >> 2];
        end
      end
      irq0 = irqCnt;
      pulseStart(32'h100);
      waitIdle();
      @(negedge clk);
      check(!busy, "R9 stops at retired self-link", {31'h0, busy}, 32'h0);
      check(errFlag == VECS[v].err, "R11 error flag",
            {31'h0, errFlag}, {31'h0, VECS[v].err});
      check((irqCnt - irq0) == int'(VECS[v].irq), "R8 end interrupt count",
            32'(irqCnt - irq0), {31'h0, VECS[v].irq});
      check(mem[32'h100 >> 2] == (VECS[v].err ? 32'hA01 : 32'hA00),
            "R7 header write-back", mem[32'h100 >> 2],
            VECS[v].err ? 32'hA01 : 32'hA00);
      bad = 0;
      for (int k = 0; k < 16; k++) if (mem[(32'h400 >> 2) + k] != expD[k]) bad++;
      check(bad == 0, "R5/R6/R4 destination contents", 32'(bad), 32'h0);
      if (VECS[v].err) begin
        repeat (4) @(negedge clk);
        check(errFlag, "R11 error flag sticky", {31'h0, errFlag}, 32'h1);
      end
    end

    // R2 and R3: invalid header, first read address and stop timing
    putDesc(32'h180, 32'h00000A00, 32'h200, 32'h400, 32'd16, 32'h80022000, 32'h180);
    wr0 = wrCnt; irq0 = irqCnt;
    pulseStart(32'h180);
    check(memReq && !memWe && memAddr == 32'h180, "R2 first header read",
          memAddr, 32'h180);
    check(busy, "R2 busy after start", {31'h0, busy}, 32'h1);
    @(negedge clk);
    @(negedge clk);
    check(busy, "R3 busy until header checked", {31'h0, busy}, 32'h1);
    @(negedge clk);
    check(!busy, "R3 stop on invalid header", {31'h0, busy}, 32'h0);
    check(wrCnt == wr0 && irqCnt == irq0 && !errFlag, "R3 no side effects",
          32'(wrCnt - wr0 + irqCnt - irq0), 32'h0);

    // R9: two-entry ring, first masked, wraps and stops on retired entry
    clearDst();
    putDesc(32'h100, 32'h1, 32'h200, 32'h400, 32'd8, 32'h81022000, 32'h140);
    putDesc(32'h140, 32'h1, 32'h210, 32'h420, 32'd8, 32'h80022000, 32'h100);
    wr0 = wrCnt; irq0 = irqCnt;
    pulseStart(32'h100);
    waitIdle();
    @(negedge clk);
    check(mem[32'h400 >> 2] == mem[32'h200 >> 2] && mem[32'h424 >> 2] == mem[32'h214 >> 2],
          "R9 both ring entries copied", mem[32'h424 >> 2], mem[32'h214 >> 2]);
    check(mem[32'h100 >> 2] == 32'h0 && mem[32'h140 >> 2] == 32'h0,
          "R7 ring headers retired", mem[32'h140 >> 2], 32'h0);
    check((irqCnt - irq0) == 1, "R8 only unmasked entry interrupts",
          32'(irqCnt - irq0), 32'h1);
    check((wrCnt - wr0) == 6, "R9 no writes after wrap", 32'(wrCnt - wr0), 32'd6);

    // R10: chaining off, next link must not run
    clearDst();
    putDesc(32'h100, 32'h1, 32'h200, 32'h400, 32'd4, 32'h00022000, 32'h140);
    putDesc(32'h140, 32'h1, 32'h210, 32'h420, 32'd4, 32'h80022000, 32'h140);
    irq0 = irqCnt;
    pulseStart(32'h100);
    waitIdle();
    @(negedge clk);
    check(mem[32'h140 >> 2] == 32'h1 && mem[32'h420 >> 2] == 32'h0,
          "R10 link not followed", mem[32'h420 >> 2], 32'h0);
    check(mem[32'h100 >> 2] == 32'h0 && (irqCnt - irq0) == 1,
          "R10 own descriptor completed", mem[32'h100 >> 2], 32'h0);

    // R2: start while busy is ignored
    clearDst();
    putDesc(32'h100, 32'h1, 32'h200, 32'h400, 32'd32, 32'h80022000, 32'h100);
    putDesc(32'h140, 32'h1, 32'h210, 32'h420, 32'd4, 32'h80022000, 32'h140);
    pulseStart(32'h100);
    repeat (3) @(negedge clk);
    pulseStart(32'h140);
    waitIdle();
    @(negedge clk);
    check(mem[32'h140 >> 2] == 32'h1 && mem[32'h420 >> 2] == 32'h0,
          "R2 start during busy ignored", mem[32'h420 >> 2], 32'h0);
    check(mem[32'h41C >> 2] == mem[32'h21C >> 2], "R5 long copy completed",
          mem[32'h41C >> 2], mem[32'h21C >> 2]);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule